// File: doc/BRIEF.md
# Byte-Wide Atomic Access Wrapper for a Wide Register

This block sits between an 8-bit register bus and a wide hardware value, such as a 16-, 24- or 32-bit counter, so that software can read and write that value one byte at a time and still get a consistent result. The wide value is owned elsewhere. This block only observes it through a parallel live-value input, and hands a complete new value back through a parallel commit output with a one-cycle strobe.

Reading byte 0, the least significant byte, returns the live byte at once. In the same clock edge it copies every higher byte of the live value into a holding buffer. Later reads of the higher bytes return the held copy, so all the bytes belong to the same instant.

Writes go the other way. Writes to the lower bytes only fill the holding buffer. A write to the most significant byte presents the full new value, made of the buffered low bytes and the new top byte, on the commit output for exactly one cycle. The owner of the value must take it in that cycle.

There is one holding buffer, shared by reads and writes. Buffer slot k holds live byte k+1 after a capture, and pending write byte k after a write.

Top module: `atomicByteReg`

## Requirements
- R1: After reset, commitStrobe is 0 and commitValue is 0. The holding buffer is cleared, so upper-byte reads return 0 and a commit of the top byte alone yields {topByte, zeros}.
- R2: A read (busRd=1) of address 0 returns liveValue[7:0] on busRdata combinationally in the same cycle. With busRd=0, busRdata is 0.
- R3: A read of address 0 with busWr=0 captures live bytes 1..N-1. A later read of address k (1..N-1) returns live byte k as it was at the capture edge, even if liveValue has changed since.
- R4: A read of an upper address with no earlier capture since reset returns the buffer contents, which is 0.
- R5: A write to addresses 0..N-2 stores busWdata in buffer slot "address". It does not pulse commitStrobe and does not change commitValue.
- R6: A write to address N-1 sets commitStrobe to 1 in the following cycle only. commitValue then equals {busWdata, slot N-2, ..., slot 0}, and it holds that value until the next top-byte write.
- R7: Because the buffer is shared, a capture read between partial writes and the top write replaces the pending bytes. The commit then carries live bytes 1..N-1 in byte positions 0..N-2.
- R8: Addresses at or above N are ignored. A read returns 0, and a write leaves the buffer and commit output unchanged.
- R9: Reading an upper byte does not change the buffer, so repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address, 0 = least significant |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| liveValue | input | 8*NUM_BYTES | Current value of the wide register |
| commitValue | output | 8*NUM_BYTES | Complete value to load into the wide register |
| commitStrobe | output | 1 | One-cycle pulse: load commitValue now |

## Verification
The checker assumes that the bus never raises busRd and busWr in the same cycle. The snapshot property also assumes that liveValue settles before the clock edge on which a byte-0 read captures it. The stimulus drives every bus and live-value input at the falling edge and makes each access either a read or a write, never both. Back-to-back top-byte writes and out-of-range addresses are driven on purpose, so the strobe and ignore properties see their edge cases.

// File: rtl/atomicRegPkg.sv
package atomicRegPkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 2;   // addresses up to 4 bytes

  typedef struct packed {
    logic              capture;   // byte-0 read: copy upper live bytes
    logic              load;      // lower-byte write into buffer
    logic              commit;    // top-byte write
    logic              rdLive;    // return live byte 0
    logic              rdShadow;  // return a buffer slot
    logic [IDX_W-1:0]  idx;       // decoded byte address
  } ctrlStrobes_t;
endpackage

// File: rtl/atomicRegCtrl.sv
module atomicRegCtrl
  import atomicRegPkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int ADDR_W    = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_BYTES - 1);

  logic inRange;
  logic isLow;
  logic isTop;

  always_comb begin
    inRange = (busAddr <= TOP_ADDR);
    isLow   = (busAddr == '0);
    isTop   = (busAddr == TOP_ADDR);

    strobes          = '0;
    strobes.idx      = IDX_W'(busAddr);
    strobes.load     = busWr && inRange && !isTop;
    strobes.commit   = busWr && isTop;
    strobes.capture  = busRd && isLow && !busWr;
    strobes.rdLive   = busRd && isLow;
    strobes.rdShadow = busRd && inRange && !isLow;
  end
endmodule

// File: rtl/atomicRegData.sv
module atomicRegData
  import atomicRegPkg::*;
#(
  parameter int NUM_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlStrobes_t                strobes,
  input  logic [BYTE_W-1:0]           busWdata,
  input  logic [BYTE_W*NUM_BYTES-1:0] liveValue,
  output logic [BYTE_W-1:0]           busRdata,
  output logic [BYTE_W*NUM_BYTES-1:0] commitValue,
  output logic                        commitStrobe
);
  localparam int SLOTS  = NUM_BYTES - 1;
  localparam int LOW_W  = BYTE_W * SLOTS;

  logic [BYTE_W-1:0] holdBuf [SLOTS];
  logic [LOW_W-1:0]  lowFlat;

  // Shared buffer: slot k = live byte k+1 after capture, or pending write byte k
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SLOTS; k++) holdBuf[k] <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (strobes.load && strobes.idx == IDX_W'(k))
          holdBuf[k] <= busWdata;
        else if (strobes.capture)
          holdBuf[k] <= liveValue[BYTE_W*(k+1) +: BYTE_W];
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gFlat
    assign lowFlat[BYTE_W*g +: BYTE_W] = holdBuf[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commitValue  <= '0;
      commitStrobe <= 1'b0;
    end else begin
      commitStrobe <= strobes.commit;
      if (strobes.commit) commitValue <= {busWdata, lowFlat};
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobes.rdLive) begin
      busRdata = liveValue[BYTE_W-1:0];
    end else if (strobes.rdShadow) begin
      for (int k = 0; k < SLOTS; k++)
        if (strobes.idx == IDX_W'(k + 1)) busRdata = holdBuf[k];
    end
  end
endmodule

// File: rtl/atomicByteReg.sv
module atomicByteReg
  import atomicRegPkg::*;
#(
  parameter int NUM_BYTES = 3,
  localparam int ADDR_W   = (NUM_BYTES > 2) ? 2 : 1,
  localparam int VAL_W    = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [VAL_W-1:0]  liveValue,
  output logic [VAL_W-1:0]  commitValue,
  output logic              commitStrobe
);
  ctrlStrobes_t strobes;

  atomicRegCtrl #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobes (strobes)
  );

  atomicRegData #(.NUM_BYTES(NUM_BYTES)) uData (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .busWdata     (busWdata),
    .liveValue    (liveValue),
    .busRdata     (busRdata),
    .commitValue  (commitValue),
    .commitStrobe (commitStrobe)
  );
endmodule

// File: rtl/atomicByteRegChecker.sv
module atomicByteRegChecker #(
  parameter int NUM_BYTES = 3,
  localparam int ADDR_W   = (NUM_BYTES > 2) ? 2 : 1,
  localparam int VAL_W    = 8 * NUM_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic [VAL_W-1:0]  liveValue,
  input logic [VAL_W-1:0]  commitValue,
  input logic              commitStrobe
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(NUM_BYTES - 1);

  logic topWr;
  assign topWr = busWr && (busAddr == TOP);

  AST_COMMIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    topWr |=> commitStrobe); // R6

  AST_NO_STRAY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !topWr |=> !commitStrobe); // R5

  AST_COMMIT_TOP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    topWr |=> commitValue[VAL_W-1 -: 8] == $past(busWdata)); // R6

  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !topWr |=> $stable(commitValue)); // R5

  AST_SNAPSHOT_BYTE1: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && !busWr && busAddr == '0) |=>
      (!(busRd && !busWr && busAddr == ADDR_W'(1)) || busRdata == $past(liveValue[15:8]))); // R3

  AST_LOW_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && busAddr == '0) |-> busRdata == liveValue[7:0]); // R2

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !busRd |-> busRdata == 8'h00); // R2
endmodule

bind atomicByteReg atomicByteRegChecker #(.NUM_BYTES(NUM_BYTES)) uChk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busAddr      (busAddr),
  .busRd        (busRd),
  .busWr        (busWr),
  .busWdata     (busWdata),
  .busRdata     (busRdata),
  .liveValue    (liveValue),
  .commitValue  (commitValue),
  .commitStrobe (commitStrobe)
);

// File: tb/sim_atomicByteReg.sv
module sim_atomicByteReg;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  busAddr;
  logic        busRd, busWr;
  logic [7:0]  busWdata, busRdata;
  logic [23:0] liveValue, commitValue;
  logic        commitStrobe;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;   // 250 MHz

  atomicByteReg #(.NUM_BYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .liveValue(liveValue),
    .commitValue(commitValue), .commitStrobe(commitStrobe)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [1:0]  addr;
    logic [7:0]  wd;
    logic [23:0] live;
    logic [7:0]  expRd;
    logic        expStb;
    logic [23:0] expCv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd1, 8'h00, 24'hABCDEF, 8'h00, 1'b0, 24'h000000, 4'd4}, // R4 upper read, no capture
    '{1'b1, 1'b0, 2'd0, 8'h00, 24'h123456, 8'h56, 1'b0, 24'h000000, 4'd2}, // R2 live low byte
    '{1'b1, 1'b0, 2'd1, 8'h00, 24'h999999, 8'h34, 1'b0, 24'h000000, 4'd3}, // R3 snapshot byte 1
    '{1'b1, 1'b0, 2'd2, 8'h00, 24'h999999, 8'h12, 1'b0, 24'h000000, 4'd3}, // R3 snapshot byte 2
    '{1'b1, 1'b0, 2'd2, 8'h00, 24'h888888, 8'h12, 1'b0, 24'h000000, 4'd9}, // R9 repeat read
    '{1'b0, 1'b1, 2'd0, 8'hA1, 24'h888888, 8'h00, 1'b0, 24'h000000, 4'd5}, // R5 low write
    '{1'b0, 1'b1, 2'd1, 8'hB2, 24'h888888, 8'h00, 1'b0, 24'h000000, 4'd5}, // R5 mid write
    '{1'b0, 1'b1, 2'd3, 8'hFF, 24'h888888, 8'h00, 1'b0, 24'h000000, 4'd8}, // R8 write out of range
    '{1'b1, 1'b0, 2'd3, 8'h00, 24'h888888, 8'h00, 1'b0, 24'h000000, 4'd8}, // R8 read out of range
    '{1'b0, 1'b1, 2'd2, 8'hC3, 24'h888888, 8'h00, 1'b1, 24'hC3B2A1, 4'd6}, // R6 commit
    '{1'b0, 1'b0, 2'd0, 8'h00, 24'h888888, 8'h00, 1'b0, 24'hC3B2A1, 4'd6}, // R6 single pulse, hold
    '{1'b0, 1'b1, 2'd0, 8'h11, 24'h888888, 8'h00, 1'b0, 24'hC3B2A1, 4'd5}, // R5 partial write
    '{1'b1, 1'b0, 2'd0, 8'h00, 24'h778899, 8'h99, 1'b0, 24'hC3B2A1, 4'd7}, // R7 capture overwrites
    '{1'b0, 1'b1, 2'd2, 8'h44, 24'h000000, 8'h00, 1'b1, 24'h447788, 4'd7}, // R7 commit of captured bytes
    '{1'b0, 1'b0, 2'd0, 8'h00, 24'h000000, 8'h00, 1'b0, 24'h447788, 4'd6}  // R6 strobe drops
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, check read data before the rising edge,
  // check commit outputs just after the rising edge
  task automatic step(input logic rd, input logic wr, input logic [1:0] addr,
                      input logic [7:0] wd, input logic [23:0] live,
                      input logic [7:0] expRd, input logic expStb,
                      input logic [23:0] expCv, input string tag);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = addr; busWdata = wd; liveValue = live;
    #1;
    check({tag, " rdata"}, {16'h0, busRdata}, {16'h0, expRd});
    @(posedge clk);
    #1;
    check({tag, " strobe"}, {23'h0, commitStrobe}, {23'h0, expStb});
    check({tag, " commit"}, commitValue, expCv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; busRd = 1'b0; busWr = 1'b0; busAddr = '0;
    busWdata = '0; liveValue = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset strobe", {23'h0, commitStrobe}, 24'h0);
    check("R1 reset commit", commitValue, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      step(VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].live,
           VEC[i].expRd, VEC[i].expStb, VEC[i].expCv,
           $sformatf("R%0d vec%0d", VEC[i].req, i));

    // R1: reset mid-operation clears buffer and commit output
    step(1'b1, 1'b0, 2'd0, 8'h00, 24'hFEDCBA, 8'hBA, 1'b0, 24'h447788, "R1 pre-reset capture");
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 commit after reset", commitValue, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 2'd1, 8'h00, 24'h123456, 8'h00, 1'b0, 24'h000000, "R1 byte1 cleared");
    step(1'b1, 1'b0, 2'd2, 8'h00, 24'h123456, 8'h00, 1'b0, 24'h000000, "R1 byte2 cleared");
    step(1'b0, 1'b1, 2'd2, 8'h5A, 24'h123456, 8'h00, 1'b1, 24'h5A0000, "R1 top-only commit");

    // R6: back-to-back top writes keep the strobe high each cycle
    step(1'b0, 1'b1, 2'd2, 8'h01, 24'h0, 8'h00, 1'b1, 24'h010000, "R6 back-to-back 1");
    step(1'b0, 1'b1, 2'd2, 8'h02, 24'h0, 8'h00, 1'b1, 24'h020000, "R6 back-to-back 2");
    step(1'b0, 1'b0, 2'd0, 8'h00, 24'h0, 8'h00, 1'b0, 24'h020000, "R6 strobe clears");

    // R2: live byte 0 tracks the input in the same cycle
    step(1'b1, 1'b0, 2'd0, 8'h00, 24'h0000C7, 8'hC7, 1'b0, 24'h020000, "R2 live tracks");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule